// File: doc/BRIEF.md
# Condition Gate for Predicated Execution

This block stores the four status flags (negative, zero, carry, overflow) and decides whether each instruction executes. Every instruction arrives with a 4-bit condition code. The gate tests that code against the stored flags and raises an execute-enable in the same cycle. An instruction whose condition fails is squashed in place. It leaves the flags untouched, and the enable tells the surrounding pipeline to drop its register write.

The execute stage presents new flag values and a request to set flags. The stored flags take the new values at the clock edge only when the instruction passes its condition. A compare can therefore be made conditional on an earlier compare. This chains tests such as "x equals zero or y below five" without any branch.

Top module: `cond_gate`

## Requirements
- R1: An active-low asynchronous reset clears all four flags. Flags are packed as `flags_o[3]`=N, `[2]`=Z, `[1]`=C, `[0]`=V.
- R2: Single-flag codes: 0000 passes when Z=1, 0001 when Z=0, 0010 when C=1, 0011 when C=0, 0100 when N=1, 0101 when N=0, 0110 when V=1, 0111 when V=0.
- R3: Code 1000 passes when C=1 and Z=0. Code 1001 passes when C=0 or Z=1.
- R4: Signed codes: 1010 passes when N equals V, and 1011 when N differs from V. 1100 passes when Z=0 and N equals V. 1101 passes when Z=1 or N differs from V.
- R5: Code 1110 passes whatever the flags hold. Code 1111 never passes.
- R6: When `valid_i` is low, `exec_o` is low for every code.
- R7: `exec_o` follows the condition in the same cycle. When `exec_o` and `set_flags_i` are both high, `flags_o` equals the `nzcv_in` value presented at that edge one clock later.
- R8: A failing instruction with `set_flags_i` high leaves `flags_o` unchanged.
- R9: A passing instruction with `set_flags_i` low leaves `flags_o` unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| valid_i | input | 1 | An instruction is present this cycle |
| cond_i | input | 4 | Condition code of the instruction |
| set_flags_i | input | 1 | The instruction requests a flag update |
| nzcv_in | input | 4 | New flag values from the execute stage |
| exec_o | output | 1 | Execute-enable for the instruction |
| flags_o | output | 4 | Stored flags N, Z, C, V |

## Verification
`exec_o` is combinational. It is due in the same cycle as the condition code and flags that decide it, so the bench reads it at the falling edge that follows input changes. A flag update lands at the next rising edge. The bench therefore reads `flags_o` at the falling edge after that edge, never at the edge itself. The sweep first loads each of the sixteen flag patterns through an always-passing update. It then drives every code with `valid_i` high and low.

// File: rtl/cond_gate.sv
module cond_gate (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       valid_i,
  input  logic [3:0] cond_i,
  input  logic       set_flags_i,
  input  logic [3:0] nzcv_in,
  output logic       exec_o,
  output logic [3:0] flags_o
);
  logic [3:0] flags_q;
  logic n, z, c, v, pass;

  assign {n, z, c, v} = flags_q;
  assign flags_o = flags_q;

  always_comb begin
    case (cond_i)
      4'h0: pass = z;
      4'h1: pass = !z;
      4'h2: pass = c;
      4'h3: pass = !c;
      4'h4: pass = n;
      4'h5: pass = !n;
      4'h6: pass = v;
      4'h7: pass = !v;
      4'h8: pass = c && !z;
      4'h9: pass = !c || z;
      4'hA: pass = n == v;
      4'hB: pass = n != v;
      4'hC: pass = !z && (n == v);
      4'hD: pass = z || (n != v);
      4'hE: pass = 1'b1;
      default: pass = 1'b0;
    endcase
  end

  assign exec_o = valid_i && pass;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) flags_q <= 4'h0;
    else if (exec_o && set_flags_i) flags_q <= nzcv_in;
  end

  p_load_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (exec_o && set_flags_i) |=> flags_o == $past(nzcv_in));
  p_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !(exec_o && set_flags_i) |=> $stable(flags_o));
  p_never_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (cond_i == 4'hF) |-> !exec_o);
  p_always_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (valid_i && cond_i == 4'hE) |-> exec_o);
  p_idle_r6: assert property (@(posedge clk) disable iff (!rst_n)
    !valid_i |-> !exec_o);
endmodule

// File: tb/test_cond_gate.sv
module test_cond_gate;
  logic clk = 0, rst_n = 0, valid_i = 0, set_flags_i = 0;
  logic [3:0] cond_i = 0, nzcv_in = 0;
  logic exec_o;
  logic [3:0] flags_o;
  int checks = 0, errors = 0;
  bit done = 0;

  always #4 clk = ~clk;

  cond_gate i_cond_gate (.clk, .rst_n, .valid_i, .cond_i, .set_flags_i,
                         .nzcv_in, .exec_o, .flags_o);

  function automatic bit expect_pass(input logic [3:0] f, input logic [3:0] cc);
    bit n = f[3], z = f[2], c = f[1], v = f[0];
    case (cc)
      0: return z;          1: return !z;
      2: return c;          3: return !c;
      4: return n;          5: return !n;
      6: return v;          7: return !v;
      8: return c & !z;     9: return !c | z;
      10: return n ~^ v;    11: return n ^ v;
      12: return !z & (n ~^ v);
      13: return z | (n ^ v);
      14: return 1;
      default: return 0;
    endcase
  endfunction

  task automatic chk(input string tag, input logic [3:0] got, input logic [3:0] exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s: got %h expected %h", tag, got, exp);
    end
  endtask

  task automatic load_flags(input logic [3:0] f);
    @(negedge clk);
    valid_i = 1; cond_i = 4'hE; set_flags_i = 1; nzcv_in = f;
    @(negedge clk);
    set_flags_i = 0;
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  endtask

  initial begin
    #1000000;
    errors++;
    $display("FAIL watchdog: got timeout expected completion");
    finish_run();
  end

  initial begin
    repeat (2) @(negedge clk);
    chk("R1 reset flags", flags_o, 4'h0);
    rst_n = 1;
    for (int f = 0; f < 16; f++) begin
      load_flags(f[3:0]);
      chk("R7 load", flags_o, f[3:0]);
      for (int cc = 0; cc < 16; cc++) begin
        string tag;
        tag = cc < 8 ? "R2 cond" : cc < 10 ? "R3 cond" : cc < 14 ? "R4 cond" : "R5 cond";
        valid_i = 1; cond_i = cc[3:0]; #1;
        chk(tag, {3'b0, exec_o}, {3'b0, expect_pass(f[3:0], cc[3:0])});
        valid_i = 0; #1;
        chk("R6 idle", {3'b0, exec_o}, 4'h0);
      end
    end
    load_flags(4'h4);
    @(negedge clk);
    valid_i = 1; cond_i = 4'h1; set_flags_i = 1; nzcv_in = 4'h9;
    @(negedge clk);
    chk("R8 failing compare", flags_o, 4'h4);
    valid_i = 1; cond_i = 4'h0; set_flags_i = 1; nzcv_in = 4'h8;
    @(negedge clk);
    chk("R7 chained compare", flags_o, 4'h8);
    valid_i = 1; cond_i = 4'hB; set_flags_i = 0; nzcv_in = 4'h3; #1;
    chk("R7 same-cycle enable", {3'b0, exec_o}, 4'h1);
    @(negedge clk);
    chk("R9 no set request", flags_o, 4'h8);
    valid_i = 0; cond_i = 4'hE; set_flags_i = 1; nzcv_in = 4'h7;
    @(negedge clk);
    chk("R6 invalid holds flags", flags_o, 4'h8);
    valid_i = 1; cond_i = 4'hF; set_flags_i = 1; nzcv_in = 4'h2;
    @(negedge clk);
    chk("R5 never holds flags", flags_o, 4'h8);
    set_flags_i = 0; valid_i = 0;
    @(negedge clk);
    rst_n = 0; #1;
    chk("R1 async clear", flags_o, 4'h0);
    finish_run();
  end
endmodule